// File: doc/BRIEF.md
# Cascaded 32-Source Bit Selector

The block picks one bit out of a 32-bit data vector with a 5-bit select and an active-low global enable. It is built from four identical 8-input selector slices instead of one flat 32-way selector. The two upper select bits are decoded into a one-hot slice enable, and the three lower select bits reach the local select of every slice. The slice results are merged into one true output and one complemented output.

A parameter picks the merge style. In OR mode every disabled slice outputs 0, and the true outputs are OR-ed together. In three-state mode each slice drives a shared node only while it is enabled. The node is modelled as a resolver, and it must never see more than one driver. With the global enable deasserted, no slice is enabled and the outputs rest at 0 and 1.

Top module: `casc_mux32`

## Requirements
- R1: With `en_ni` low, `y_o` equals `data_i[sel_i]` for every one of the 32 select values.
- R2: `yn_o` is always the inverse of `y_o`.
- R3: With `en_ni` high, `y_o` is 0 and `yn_o` is 1 whatever `data_i` and `sel_i` hold.
- R4: Slice g serves data bits 8g+7 down to 8g, and it is chosen when `sel_i[4:3]` equals g. `sel_i[2:0]` picks the bit inside that slice.
- R5: With `en_ni` low exactly one slice is enabled; with `en_ni` high none is. A bit set only outside the selected slice never reaches `y_o`.
- R6: OR-merge and three-state-merge builds give identical outputs for identical inputs.
- R7: In three-state mode the shared node has exactly one driver while enabled and none while disabled. The undriven node resolves to `y_o`=0, `yn_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_ni | input | 1 | Global enable, active low |
| sel_i | input | 5 | Source select; bits 4:3 pick the slice, bits 2:0 the bit within it |
| data_i | input | 32 | The 32 data sources |
| y_o | output | 1 | Selected bit |
| yn_o | output | 1 | Complement of the selected bit |

## Verification
The bench builds two copies side by side on the same inputs, one with the OR merge and one with the modelled three-state merge. This makes the two merge paths comparable cycle by cycle, and it puts the single-driver rule of the shared node under the bound checks during every vector. A walking-one sweep over all 32 positions and all 32 select values shows that each data bit reaches the output only through its own slice and its own low select code. Sweeps with the enable released show that no data pattern leaks out of either build.

// File: rtl/casc_mux_pkg.sv
package casc_mux_pkg;
  typedef enum logic {
    MERGE_OR  = 1'b0,
    MERGE_TRI = 1'b1
  } merge_e;
endpackage

// File: rtl/casc_mux_dec.sv
module casc_mux_dec #(
  parameter int N_OUT = 4,
  parameter int IN_W  = 2
) (
  input  logic             en_i,
  input  logic [IN_W-1:0]  code_i,
  output logic [N_OUT-1:0] hot_o
);
  always_comb begin
    hot_o = '0;
    if (en_i) hot_o[code_i] = 1'b1;
  end
endmodule

// File: rtl/casc_mux_slice.sv
module casc_mux_slice #(
  parameter int SLICE_W = 8,
  parameter int LO_W    = 3
) (
  input  logic               en_ni,
  input  logic [LO_W-1:0]    sel_i,
  input  logic [SLICE_W-1:0] data_i,
  output logic               y_o,
  output logic               yn_o,
  output logic               oe_o
);
  always_comb begin
    oe_o = ~en_ni;
    y_o  = oe_o & data_i[sel_i];  // disabled slice reads 0
    yn_o = ~y_o;
  end
endmodule

// File: rtl/casc_mux_merge.sv
module casc_mux_merge
  import casc_mux_pkg::*;
#(
  parameter int     N_SRC = 4,
  parameter merge_e MODE  = MERGE_OR
) (
  input  logic [N_SRC-1:0] val_i,
  input  logic [N_SRC-1:0] valn_i,
  input  logic [N_SRC-1:0] oe_i,
  output logic             y_o,
  output logic             yn_o
);
  if (MODE == MERGE_OR) begin : g_or
    always_comb begin
      y_o  = |(val_i & oe_i);
      yn_o = &(valn_i | ~oe_i);
    end
  end else begin : g_tri
    // shared node model: pull levels when floating, single driver checked elsewhere
    always_comb begin
      y_o  = 1'b0;
      yn_o = 1'b1;
      for (int i = 0; i < N_SRC; i++) begin
        if (oe_i[i]) begin
          y_o  = val_i[i];
          yn_o = valn_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/casc_mux32.sv
module casc_mux32
  import casc_mux_pkg::*;
#(
  parameter int     N_SLICES = 4,
  parameter int     SLICE_W  = 8,
  parameter merge_e MERGE    = MERGE_OR,
  localparam int    LO_W     = $clog2(SLICE_W),
  localparam int    HI_W     = $clog2(N_SLICES),
  localparam int    SEL_W    = LO_W + HI_W,
  localparam int    DATA_W   = N_SLICES * SLICE_W
) (
  input  logic              en_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              y_o,
  output logic              yn_o
);
  logic [N_SLICES-1:0] slice_en;
  logic [N_SLICES-1:0] slice_y;
  logic [N_SLICES-1:0] slice_yn;
  logic [N_SLICES-1:0] drv_en;

  casc_mux_dec #(.N_OUT(N_SLICES), .IN_W(HI_W)) u_dec (
    .en_i   (~en_ni),
    .code_i (sel_i[SEL_W-1:LO_W]),
    .hot_o  (slice_en)
  );

  for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
    casc_mux_slice #(.SLICE_W(SLICE_W), .LO_W(LO_W)) u_slice (
      .en_ni  (~slice_en[g]),
      .sel_i  (sel_i[LO_W-1:0]),
      .data_i (data_i[g*SLICE_W +: SLICE_W]),
      .y_o    (slice_y[g]),
      .yn_o   (slice_yn[g]),
      .oe_o   (drv_en[g])
    );
  end

  casc_mux_merge #(.N_SRC(N_SLICES), .MODE(MERGE)) u_merge (
    .val_i  (slice_y),
    .valn_i (slice_yn),
    .oe_i   (drv_en),
    .y_o    (y_o),
    .yn_o   (yn_o)
  );
endmodule

// File: rtl/casc_mux32_chk.sv
module casc_mux32_chk
  import casc_mux_pkg::*;
#(
  parameter int     N_SLICES = 4,
  parameter int     SLICE_W  = 8,
  parameter merge_e MERGE    = MERGE_OR,
  parameter int     SEL_W    = 5
) (
  input logic                        en_ni,
  input logic [SEL_W-1:0]            sel_i,
  input logic [N_SLICES*SLICE_W-1:0] data_i,
  input logic                        y_o,
  input logic                        yn_o,
  input logic [N_SLICES-1:0]         slice_en,
  input logic [N_SLICES-1:0]         drv_en
);
  always_comb begin
    if (!en_ni) AST_SEL_MATCH: assert (y_o == data_i[sel_i]); // R1
    AST_COMPLEMENT: assert (yn_o == ~y_o); // R2
    if (en_ni) AST_OFF_LEVELS: assert (!y_o && yn_o); // R3
    AST_ONE_SLICE: assert ($countones(slice_en) == (en_ni ? 0 : 1)); // R5
    if (MERGE == MERGE_TRI)
      AST_ONE_DRIVER: assert ($countones(drv_en) == (en_ni ? 0 : 1)); // R7
  end
endmodule

bind casc_mux32 casc_mux32_chk #(
  .N_SLICES (N_SLICES),
  .SLICE_W  (SLICE_W),
  .MERGE    (MERGE),
  .SEL_W    (SEL_W)
) u_chk (.*);

// File: tb/tb_casc_mux32.sv
module tb_casc_mux32;
  import casc_mux_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        en_ni;
  logic [4:0]  sel;
  logic [31:0] data;
  logic        y, yn, y_t, yn_t;

  casc_mux32 #(.MERGE(MERGE_OR)) dut (
    .en_ni(en_ni), .sel_i(sel), .data_i(data), .y_o(y), .yn_o(yn));
  casc_mux32 #(.MERGE(MERGE_TRI)) dut_ts (
    .en_ni(en_ni), .sel_i(sel), .data_i(data), .y_o(y_t), .yn_o(yn_t));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        en_n;
    logic [4:0]  sel;
    logic [31:0] data;
    logic        exp_y;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 5'd0,  32'h0000_0001, 1'b1},
    '{1'b0, 5'd31, 32'h8000_0000, 1'b1},
    '{1'b0, 5'd8,  32'hFFFF_FEFF, 1'b0},
    '{1'b0, 5'd15, 32'h0000_8000, 1'b1},
    '{1'b0, 5'd16, 32'h0001_0000, 1'b1},
    '{1'b0, 5'd23, 32'hFF7F_FFFF, 1'b0},
    '{1'b1, 5'd31, 32'hFFFF_FFFF, 1'b0},
    '{1'b0, 5'd7,  32'h0000_0080, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sel=%0d en_ni=%0b data=%h act=%0b exp=%0b",
               req, sel, en_ni, data, act, exp);
    end
  endtask

  task automatic apply(input logic e, input logic [4:0] s, input logic [31:0] d);
    @(posedge clk);
    en_ni = e; sel = s; data = d;
    @(negedge clk);
  endtask

  task automatic chk_all(input logic exp_y);
    chk("R1/R4 y", y, exp_y);
    chk("R2 yn", yn, ~exp_y);
    chk("R6/R7 tri y", y_t, exp_y);
    chk("R6/R7 tri yn", yn_t, ~exp_y);
  endtask

  initial begin
    en_ni = 1'b1; sel = 5'd0; data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R3 reset-time idle levels
    chk("R3 y idle", y, 1'b0);
    chk("R3 yn idle", yn, 1'b1);
    chk("R7 tri idle", y_t, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) begin
      apply(VECS[i].en_n, VECS[i].sel, VECS[i].data);
      chk_all(VECS[i].exp_y);
    end

    // R1 full select sweep over two patterns
    for (int s = 0; s < 32; s++) begin
      apply(1'b0, 5'(s), 32'hA5C3_96E1);
      chk_all(32'hA5C3_96E1 >> s & 32'd1);
      apply(1'b0, 5'(s), 32'h5A3C_691E);
      chk_all(32'h5A3C_691E >> s & 32'd1);
    end

    // R4 R5 walking one: bit k reaches y only when sel == k
    for (int k = 0; k < 32; k++) begin
      for (int s = 0; s < 32; s++) begin
        apply(1'b0, 5'(s), 32'd1 << k);
        chk_all(s == k);
      end
    end

    // R5 bits outside the selected slice only
    for (int g = 0; g < 4; g++) begin
      apply(1'b0, 5'(g * 8 + 3), ~(32'hFF << (g * 8)));
      chk_all(1'b0);
    end

    // R3 disabled: no leak with all ones
    for (int s = 0; s < 32; s++) begin
      apply(1'b1, 5'(s), 32'hFFFF_FFFF);
      chk("R3 y off", y, 1'b0);
      chk("R3 yn off", yn, 1'b1);
      chk("R7 tri y off", y_t, 1'b0);
      chk("R7 tri yn off", yn_t, 1'b1);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule